// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block arbitrates a set of maskable interrupt request lines for a CPU core. Each source holds a pending flag, a mask bit and a 3-bit programmable level. The lowest numbered level is the most urgent. Every cycle the block picks one winner among the unmasked pending sources. It offers the winner to the CPU as a request together with the source index and its level. The CPU takes the request by raising acknowledge.

An 8-bit in-service register records which levels are being serviced. A new request may interrupt a running handler only if its level is strictly more urgent than every level in service. A global disable flag is set automatically on each acknowledge. While the flag is set, no request reaches the CPU, so a handler must issue an enable command before it can be nested. A return strobe closes the most urgent level in service.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After reset the request output is low, the disable flag is 1 and the in-service register is 0. All pending flags are cleared, all sources are masked and every level is 7.
- R2: A configuration write with `cfg_we_i` high stores `cfg_mask_i` (1 = masked) and `cfg_prio_i` (0 = most urgent, 7 = least urgent) for source `cfg_idx_i`. The new values take effect from the next cycle.
- R3: A high `irq_i[i]` in any cycle sets the pending flag of source i. A masked source is never offered, but its pending flag is kept, and the source is offered once it is unmasked.
- R4: The winner is the unmasked pending source with the numerically lowest level. Among sources tied on level, the lowest source index wins. `irq_vec_o` and `irq_lvl_o` carry the winner's index and level while `irq_req_o` is high.
- R5: `irq_req_o` is low whenever the disable flag is 1 or no unmasked source is pending.
- R6: A cycle with `irq_req_o` and `irq_ack_i` both high is a grant. On a grant the winner's pending flag is cleared, unless `irq_i` sets it again in the same cycle. A grant also sets the in-service bit of the winner's level and sets the disable flag.
- R7: `ei_i` clears the disable flag. If a grant falls in the same cycle, the flag ends at 1.
- R8: The request is offered only if the winner's level is strictly below the lowest-numbered set bit of the in-service register. When a level equal to or less urgent than that bit is pending, it waits.
- R9: `reti_i` clears the lowest-numbered set bit of the in-service register. If a grant falls in the same cycle, the clear applies to the old value, and then the granted level's bit is set.
- R10: `reti_i` with an empty in-service register leaves the register at 0 and does not change the disable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_SRC | Request lines, one per source, sampled every cycle |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Source addressed by the write |
| cfg_mask_i | input | 1 | Mask value to store (1 = masked) |
| cfg_prio_i | input | 3 | Level to store (0 most urgent) |
| irq_req_o | output | 1 | Request to the CPU |
| irq_vec_o | output | IDX_W | Index of the winning source |
| irq_lvl_o | output | 3 | Level of the winning source |
| irq_ack_i | input | 1 | CPU acknowledge |
| ei_i | input | 1 | Enable command, clears the disable flag |
| reti_i | input | 1 | Return strobe, closes the most urgent level in service |
| int_dis_o | output | 1 | Global disable flag |
| isr_o | output | 8 | In-service register, bit n = level n active |

## Verification
A grant can fall in the same cycle as an enable command. The grant sets the disable flag and the enable clears it, so the bench forces both in one cycle and expects the flag to read 1. A grant can also fall in the same cycle as a return strobe. The bench provokes this with a handler in service, and expects the old lowest in-service bit to be gone and the new level's bit to be set. The random phase raises acknowledge, enable and return independently, so these collisions also arise many times without being planned. Each cycle is compared against a reference model built from the requirements.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int unsigned LVL_W   = 3;
  localparam int unsigned NUM_LVL = 1 << LVL_W;

  typedef logic [LVL_W-1:0]   lvl_t;
  typedef logic [NUM_LVL-1:0] lvl_vec_t;

  typedef struct packed {
    logic pend;
    logic mask;
    lvl_t prio;
  } src_ctl_t;
endpackage

// File: rtl/nic_src_regs.sv
module nic_src_regs
  import nic_pkg::*;
#(
  parameter int unsigned N_SRC = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_i,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic             cfg_mask_i,
  input  lvl_t             cfg_prio_i,
  input  logic             grant_i,
  input  logic [IDX_W-1:0] grant_idx_i,
  output src_ctl_t         ctl_o [N_SRC]
);

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic sel_cfg, sel_grant;
    assign sel_cfg   = cfg_we_i && (cfg_idx_i == IDX_W'(g));
    assign sel_grant = grant_i  && (grant_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctl_o[g].pend <= 1'b0;
        ctl_o[g].mask <= 1'b1;
        ctl_o[g].prio <= '1;
      end else begin
        // a new edge in the grant cycle keeps the flag set
        ctl_o[g].pend <= irq_i[g] | (ctl_o[g].pend & ~sel_grant);
        if (sel_cfg) begin
          ctl_o[g].mask <= cfg_mask_i;
          ctl_o[g].prio <= cfg_prio_i;
        end
      end
    end
  end

endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
  import nic_pkg::*;
#(
  parameter int unsigned N_SRC = 16,
  parameter int unsigned IDX_W = 4
) (
  input  src_ctl_t         ctl_i [N_SRC],
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o,
  output lvl_t             lvl_o
);

  // ascending scan with strict compare: ties keep the lower index
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '1;
    for (int i = 0; i < N_SRC; i++) begin
      if (ctl_i[i].pend && !ctl_i[i].mask &&
          (!found_o || (ctl_i[i].prio < lvl_o))) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        lvl_o   = ctl_i[i].prio;
      end
    end
  end

endmodule

// File: rtl/nic_isr_track.sv
module nic_isr_track
  import nic_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     grant_i,
  input  lvl_t     grant_lvl_i,
  input  logic     ei_i,
  input  logic     reti_i,
  output lvl_vec_t isr_o,
  output logic     dis_o,
  output logic     cur_valid_o,
  output lvl_t     cur_lvl_o
);

  lvl_vec_t low_bit, set_bit, isr_d;

  assign low_bit = isr_o & (~isr_o + lvl_vec_t'(1));
  assign set_bit = grant_i ? (lvl_vec_t'(1) << grant_lvl_i) : '0;
  assign isr_d   = (isr_o & ~(reti_i ? low_bit : '0)) | set_bit;

  always_comb begin
    cur_valid_o = 1'b0;
    cur_lvl_o   = '0;
    for (int l = NUM_LVL - 1; l >= 0; l--) begin
      if (isr_o[l]) begin
        cur_valid_o = 1'b1;
        cur_lvl_o   = lvl_t'(l);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_o <= '0;
      dis_o <= 1'b1;
    end else begin
      isr_o <= isr_d;
      if (grant_i)   dis_o <= 1'b1;
      else if (ei_i) dis_o <= 1'b0;
    end
  end

endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
  import nic_pkg::*;
#(
  parameter  int unsigned N_SRC = 16,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SRC-1:0]   irq_i,
  input  logic               cfg_we_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic               cfg_mask_i,
  input  logic [LVL_W-1:0]   cfg_prio_i,
  output logic               irq_req_o,
  output logic [IDX_W-1:0]   irq_vec_o,
  output logic [LVL_W-1:0]   irq_lvl_o,
  input  logic               irq_ack_i,
  input  logic               ei_i,
  input  logic               reti_i,
  output logic               int_dis_o,
  output logic [NUM_LVL-1:0] isr_o
);

  src_ctl_t         ctl [N_SRC];
  logic [N_SRC-1:0] src_mask;
  logic             found, grant, cur_valid, preempt_ok;
  logic [IDX_W-1:0] win_idx;
  lvl_t             win_lvl, cur_lvl;

  for (genvar g = 0; g < N_SRC; g++) begin : g_mask
    assign src_mask[g] = ctl[g].mask;
  end

  nic_src_regs #(.N_SRC(N_SRC), .IDX_W(IDX_W)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_i       (irq_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_idx_i   (cfg_idx_i),
    .cfg_mask_i  (cfg_mask_i),
    .cfg_prio_i  (cfg_prio_i),
    .grant_i     (grant),
    .grant_idx_i (win_idx),
    .ctl_o       (ctl)
  );

  nic_arbiter #(.N_SRC(N_SRC), .IDX_W(IDX_W)) i_arb (
    .ctl_i   (ctl),
    .found_o (found),
    .idx_o   (win_idx),
    .lvl_o   (win_lvl)
  );

  nic_isr_track i_isr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .grant_i     (grant),
    .grant_lvl_i (win_lvl),
    .ei_i        (ei_i),
    .reti_i      (reti_i),
    .isr_o       (isr_o),
    .dis_o       (int_dis_o),
    .cur_valid_o (cur_valid),
    .cur_lvl_o   (cur_lvl)
  );

  assign preempt_ok = !cur_valid || (win_lvl < cur_lvl);
  assign irq_req_o  = found && preempt_ok && !int_dis_o;
  assign grant      = irq_req_o && irq_ack_i;
  assign irq_vec_o  = win_idx;
  assign irq_lvl_o  = win_lvl;

endmodule

// File: rtl/nic_checker.sv
module nic_checker
  import nic_pkg::*;
#(
  parameter int unsigned N_SRC = 16,
  parameter int unsigned IDX_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               ack_i,
  input logic [IDX_W-1:0]   vec_i,
  input logic [LVL_W-1:0]   lvl_i,
  input logic               dis_i,
  input logic [NUM_LVL-1:0] isr_i,
  input logic               ei_i,
  input logic               reti_i,
  input logic [N_SRC-1:0]   mask_i
);

  logic               grant;
  logic [NUM_LVL-1:0] at_or_above;
  assign grant       = req_i && ack_i;
  assign at_or_above = (NUM_LVL'(2) << lvl_i) - NUM_LVL'(1);

  p_masked_never_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> !mask_i[vec_i]);

  p_no_req_when_disabled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |-> !req_i);

  p_grant_sets_dis_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant |=> dis_i);

  p_grant_sets_isr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant |=> isr_i[$past(lvl_i)]);

  p_ei_clears_dis_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ei_i && !grant) |=> !dis_i);

  p_strict_preempt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> ((isr_i & at_or_above) == '0));

  p_reti_pops_one_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !grant && (isr_i != '0)) |=>
      ($countones(isr_i) == $countones($past(isr_i)) - 1));

  p_reti_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !grant && (isr_i == '0)) |=> (isr_i == '0));

endmodule

bind nested_irq_ctrl nic_checker #(.N_SRC(N_SRC), .IDX_W(IDX_W)) i_nic_checker (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (irq_req_o),
  .ack_i  (irq_ack_i),
  .vec_i  (irq_vec_o),
  .lvl_i  (irq_lvl_o),
  .dis_i  (int_dis_o),
  .isr_i  (isr_o),
  .ei_i   (ei_i),
  .reti_i (reti_i),
  .mask_i (src_mask)
);

// File: tb/test_nested_irq_ctrl.sv
module test_nested_irq_ctrl;
  localparam int N   = 16;
  localparam int IW  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq = '0;
  logic          we = 1'b0;
  logic [IW-1:0] idx = '0;
  logic          msk = 1'b0;
  logic [2:0]    pr = '0;
  logic          req;
  logic [IW-1:0] vec;
  logic [2:0]    lvl;
  logic          ack = 1'b0, ei = 1'b0, reti = 1'b0;
  logic          dis;
  logic [7:0]    isr;

  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nested_irq_ctrl #(.N_SRC(N)) i_nested_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .cfg_we_i(we), .cfg_idx_i(idx),
    .cfg_mask_i(msk), .cfg_prio_i(pr), .irq_req_o(req), .irq_vec_o(vec),
    .irq_lvl_o(lvl), .irq_ack_i(ack), .ei_i(ei), .reti_i(reti),
    .int_dis_o(dis), .isr_o(isr)
  );

  // reference model state
  bit       m_pend [N];
  bit       m_mask [N];
  int       m_prio [N];
  bit [7:0] m_isr;
  bit       m_dis;
  bit       e_req;
  int       e_vec, e_lvl;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_eval();
    bit found = 0;
    int cur = 8;
    e_vec = 0; e_lvl = 7;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && !m_mask[i] && (!found || m_prio[i] < e_lvl)) begin
        found = 1; e_vec = i; e_lvl = m_prio[i];
      end
    for (int l = 7; l >= 0; l--) if (m_isr[l]) cur = l;
    e_req = found && (e_lvl < cur) && !m_dis;
  endfunction

  task automatic step(input logic [N-1:0] i_irq, input bit i_we, input int i_idx,
                      input bit i_msk, input int i_pr, input bit i_ack,
                      input bit i_ei, input bit i_reti);
    bit g;
    @(negedge clk);
    irq = i_irq; we = i_we; idx = IW'(i_idx); msk = i_msk; pr = 3'(i_pr);
    ack = i_ack; ei = i_ei; reti = i_reti;
    #1;
    model_eval();
    check("R5 req", int'(req), int'(e_req));
    if (e_req) begin
      check("R4 vec", int'(vec), e_vec);
      check("R2 lvl", int'(lvl), e_lvl);
    end
    check("R6 dis", int'(dis), int'(m_dis));
    check("R9 isr", int'(isr), int'(m_isr));
    @(posedge clk);
    g = e_req && i_ack;
    for (int i = 0; i < N; i++) begin
      if (g && i == e_vec) m_pend[i] = 0;
      if (i_irq[i]) m_pend[i] = 1;
    end
    if (i_we) begin m_mask[i_idx] = i_msk; m_prio[i_idx] = i_pr; end
    if (i_reti && m_isr != 0) m_isr = m_isr & ~(m_isr & (~m_isr + 8'd1));
    if (g) m_isr[e_lvl] = 1'b1;
    if (g) m_dis = 1; else if (i_ei) m_dis = 0;
    #1;
    irq = '0; we = 0; ack = 0; ei = 0; reti = 0;
  endtask

  task automatic idle(); step('0, 0, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_mask[i] = 1; m_prio[i] = 7; end
    m_isr = '0; m_dis = 1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    check("R1 req after reset", int'(req), 0);
    check("R1 dis after reset", int'(dis), 1);
    check("R1 isr after reset", int'(isr), 0);

    for (int i = 0; i < N; i++) step('0, 1, i, 0, 7, 0, 0, 0);
    step('0, 0, 0, 0, 0, 0, 1, 0);
    check("R1 nothing pending", int'(req), 0);

    // masked source keeps its pending flag
    step('0, 1, 5, 1, 2, 0, 0, 0);
    step(16'h0020, 0, 0, 0, 0, 0, 0, 0);
    idle(); idle();
    check("R3 masked not offered", int'(req), 0);
    step('0, 1, 5, 0, 2, 0, 0, 0);
    check("R3 unmasked offered", int'(req), 1);
    check("R3 vec", int'(vec), 5);
    step('0, 0, 0, 0, 0, 1, 0, 0);
    check("R6 dis after grant", int'(dis), 1);
    check("R6 isr after grant", int'(isr), 8'b0000_0100);
    check("R6 pending cleared", int'(req), 0);

    // equal level waits, more urgent preempts, ties go to lower index
    step('0, 0, 0, 0, 0, 0, 1, 0);
    step('0, 1, 9, 0, 2, 0, 0, 0);
    step(16'h0200, 0, 0, 0, 0, 0, 0, 0);
    check("R8 equal level waits", int'(req), 0);
    step('0, 1, 12, 0, 1, 0, 0, 0);
    step('0, 1, 4, 0, 1, 0, 0, 0);
    step(16'h1010, 0, 0, 0, 0, 0, 0, 0);
    check("R8 more urgent preempts", int'(req), 1);
    check("R4 tie lower index", int'(vec), 4);
    step('0, 0, 0, 0, 0, 1, 1, 0);
    check("R7 ack with ei keeps dis", int'(dis), 1);
    check("R6 nested isr", int'(isr), 8'b0000_0110);

    step('0, 0, 0, 0, 0, 0, 0, 1);
    check("R9 reti pops lowest", int'(isr), 8'b0000_0100);
    check("R5 disabled no req", int'(req), 0);
    step('0, 0, 0, 0, 0, 0, 1, 0);
    check("R7 ei clears dis", int'(dis), 0);
    check("R8 vec", int'(vec), 12);
    step('0, 0, 0, 0, 0, 1, 0, 1);
    check("R9 reti with grant", int'(isr), 8'b0000_0010);
    step('0, 0, 0, 0, 0, 0, 0, 1);
    step('0, 0, 0, 0, 0, 0, 0, 1);
    check("R10 reti empty isr", int'(isr), 0);
    check("R10 reti keeps dis", int'(dis), 1);

    // random phase
    step('0, 0, 0, 0, 0, 0, 1, 0);
    for (int c = 0; c < 4000; c++) begin
      logic [N-1:0] r_irq;
      int r_pr;
      bit r_msk;
      r_irq = N'($urandom & $urandom & $urandom);
      r_msk = ($urandom_range(3) == 0);
      r_pr  = $urandom_range(7);
      step(r_irq, ($urandom_range(7) == 0), $urandom_range(N - 1), r_msk, r_pr,
           ($urandom_range(1) == 1), ($urandom_range(3) == 0),
           ($urandom_range(5) == 0));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule